// File: doc/BRIEF.md
# Lockable CMOS RAM Access Controller

This block holds a 256-byte configuration RAM of the battery-backed kind. Software reaches it through two pairs of I/O ports at 70h–73h. In each pair, one port selects a byte (the index port) and the other moves the data (the data port). The lower pair serves bytes 00h–7Fh and the upper pair serves bytes 80h–FFh.

An 8-bit control register, at its own configuration address, sits beside the RAM. It carries two sticky protection bits. Each protection bit guards one fixed eight-byte window of the RAM. While a window is guarded, software cannot change its bytes, and every read of them returns all ones. Software can set a protection bit, but only the power-good reset clears it. The ordinary system reset leaves both protection bits alone.

The remaining control bits are plain storage, except one bit that is write-only. Writing 1 to that bit emits a one-cycle reset request pulse.

Top module: `lockable_cmos_ctrl`

## Requirements
- R1: An I/O write to port offset 0 latches bits 6:0 of the data as the lower-bank index, and a write to offset 2 latches the upper-bank index. Bit 7 of the written value is discarded.
- R2: An access to offset 1 reaches byte {0, lower index}, and an access to offset 3 reaches byte {1, upper index}. For a read, io_rvalid is 1 on the clock after the request and io_rdata holds the byte. When no read is answered, io_rvalid is 0 and io_rdata is 00h. An unguarded write is seen by the next read of that byte.
- R3: A read of offset 0 or 2 returns the latched index of that bank, with bit 7 reading 0, one clock after the request.
- R4: Control bit 0 guards bytes 38h–3Fh and control bit 1 guards bytes B8h–BFh. Writing 1 sets the bit, and writing 0 leaves it unchanged.
- R5: Only pwrgood_rst_n clears the two guard bits. Asserting rst_n does not change them.
- R6: A read of any byte in a guarded window returns FFh.
- R7: A write to any byte in a guarded window is discarded. The byte keeps its old value, and that value is read back once the guard is removed by a power-good reset.
- R8: Bytes outside a guarded window, including the bytes next to it, behave as ordinary read-write RAM while the guard is set.
- R9: Control bits 7:3 are plain read-write storage and reset to 0 on rst_n.
- R10: Control bit 2 is write-only and always reads 0. Writing it with 1 drives sw_rst_pulse high for exactly the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| pwrgood_rst_n | input | 1 | Power-good reset for the guard bits, active low |
| io_req | input | 1 | I/O access strobe, one cycle per access |
| io_we | input | 1 | 1 = write, 0 = read |
| io_port | input | 2 | Port offset from 70h (0..3) |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, valid with io_rvalid |
| io_rvalid | output | 1 | Read answer valid |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read value |
| sw_rst_pulse | output | 1 | One-cycle reset request |

## Verification
A lost or spurious guard bit is visible at once on cfg_rdata. It also shows on the next read of a window byte, which returns a value other than FFh one clock after the request, or FFh where the RAM value was expected. A discarded write that leaked into the array stays hidden while the guard holds. It appears only after a power-good reset, so the bench deliberately writes into guarded windows and reads them back after unlocking. A wrong index latch shows on the index read-back and on the following data-port access.

// File: rtl/lcmos_pkg.sv
package lcmos_pkg;
   typedef enum logic [1:0] {
      PORT_IDX_LO = 2'd0,
      PORT_DAT_LO = 2'd1,
      PORT_IDX_HI = 2'd2,
      PORT_DAT_HI = 2'd3
   } io_port_e;

   typedef struct packed {
      logic       valid;
      io_port_e   src;
      logic       blocked;
   } rd_tag_t;
endpackage

// File: rtl/lcmos_index_regs.sv
module lcmos_index_regs #(
   parameter int IDX_W  = 7,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [DATA_W-1:0] wdata,
   output logic [IDX_W-1:0]  idx_lo,
   output logic [IDX_W-1:0]  idx_hi
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_lo <= '0;
         idx_hi <= '0;
      end else begin
         if (wr_lo) idx_lo <= wdata[IDX_W-1:0];
         if (wr_hi) idx_hi <= wdata[IDX_W-1:0];
      end
   end
endmodule

// File: rtl/lcmos_ctrl_reg.sv
module lcmos_ctrl_reg #(
   parameter int DATA_W    = 8,
   parameter int NUM_WIN   = 2,
   parameter int PULSE_BIT = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pwrgood_rst_n,
   input  logic               cfg_we,
   input  logic [DATA_W-1:0]  cfg_wdata,
   output logic [NUM_WIN-1:0] locks,
   output logic [DATA_W-1:0]  cfg_rdata,
   output logic               sw_rst_pulse
);
   function automatic logic [DATA_W-1:0] calc_plain_mask();
      logic [DATA_W-1:0] m;
      for (int b = 0; b < DATA_W; b++) begin
         m[b] = (b >= NUM_WIN) && (b != PULSE_BIT);
      end
      return m;
   endfunction

   localparam logic [DATA_W-1:0] PLAIN_MASK = calc_plain_mask();

   logic [NUM_WIN-1:0] lock_q;
   logic [DATA_W-1:0]  plain_q;
   logic               pulse_q;

   // guard bits live in the power-good domain; software can only set them
   always_ff @(posedge clk or negedge pwrgood_rst_n) begin
      if (!pwrgood_rst_n) begin
         lock_q <= '0;
      end else if (cfg_we) begin
         lock_q <= lock_q | cfg_wdata[NUM_WIN-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         plain_q <= '0;
         pulse_q <= 1'b0;
      end else begin
         if (cfg_we) plain_q <= cfg_wdata & PLAIN_MASK;
         pulse_q <= cfg_we && cfg_wdata[PULSE_BIT];
      end
   end

   assign locks        = lock_q;
   assign cfg_rdata    = plain_q | {{(DATA_W-NUM_WIN){1'b0}}, lock_q};
   assign sw_rst_pulse = pulse_q;
endmodule

// File: rtl/lcmos_lock_match.sv
module lcmos_lock_match #(
   parameter int ADDR_W    = 8,
   parameter int NUM_WIN   = 2,
   parameter int SPAN_LOG2 = 3,
   parameter logic [NUM_WIN*ADDR_W-1:0] WIN_BASES = 16'hB838
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic [NUM_WIN-1:0] locks,
   output logic               blocked
);
   logic [NUM_WIN-1:0] hit;

   for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
      localparam logic [ADDR_W-1:0] BASE = WIN_BASES[i*ADDR_W +: ADDR_W];
      assign hit[i] = locks[i] &&
                      (addr[ADDR_W-1:SPAN_LOG2] == BASE[ADDR_W-1:SPAN_LOG2]);
   end

   assign blocked = |hit;
endmodule

// File: rtl/lcmos_ram.sv
module lcmos_ram #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic              re,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   // contents survive system reset by intent: no reset on the array
   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
      if (re) rdata <= mem[addr];
   end
endmodule

// File: rtl/lockable_cmos_ctrl.sv
module lockable_cmos_ctrl
   import lcmos_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter int IDX_W          = 7,
   parameter int NUM_WIN        = 2,
   parameter int SPAN_LOG2      = 3,
   parameter int CTRL_PULSE_BIT = 2,
   parameter logic [DATA_W-1:0] LOCK_FILL = 8'hFF,
   parameter logic [NUM_WIN*(IDX_W+1)-1:0] WIN_BASES = 16'hB838
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwrgood_rst_n,
   input  logic              io_req,
   input  logic              io_we,
   input  logic [1:0]        io_port,
   input  logic [DATA_W-1:0] io_wdata,
   output logic [DATA_W-1:0] io_rdata,
   output logic              io_rvalid,
   input  logic              cfg_we,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   output logic              sw_rst_pulse
);
   localparam int ADDR_W = IDX_W + 1;

   if (CTRL_PULSE_BIT < NUM_WIN || CTRL_PULSE_BIT >= DATA_W) begin : g_bad_pulse
      $error("pulse bit must sit above the guard bits inside the register");
   end
   if (SPAN_LOG2 >= ADDR_W) begin : g_bad_span
      $error("window span must be smaller than the array");
   end
   if (IDX_W >= DATA_W) begin : g_bad_idx
      $error("index must fit in a data byte");
   end

   io_port_e            port;
   logic [IDX_W-1:0]    idx_lo, idx_hi;
   logic [ADDR_W-1:0]   acc_addr;
   logic [NUM_WIN-1:0]  locks;
   logic                acc_blocked;
   logic                data_acc;
   logic [DATA_W-1:0]   ram_rdata;
   logic [IDX_W-1:0]    idx_snap_q;
   rd_tag_t             tag_q;

   assign port     = io_port_e'(io_port);
   assign data_acc = io_req && (port == PORT_DAT_LO || port == PORT_DAT_HI);
   assign acc_addr = (port == PORT_DAT_HI) ? {1'b1, idx_hi} : {1'b0, idx_lo};

   lcmos_index_regs #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_idx (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_lo  (io_req && io_we && port == PORT_IDX_LO),
      .wr_hi  (io_req && io_we && port == PORT_IDX_HI),
      .wdata  (io_wdata),
      .idx_lo (idx_lo),
      .idx_hi (idx_hi)
   );

   lcmos_ctrl_reg #(
      .DATA_W(DATA_W), .NUM_WIN(NUM_WIN), .PULSE_BIT(CTRL_PULSE_BIT)
   ) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .pwrgood_rst_n (pwrgood_rst_n),
      .cfg_we        (cfg_we),
      .cfg_wdata     (cfg_wdata),
      .locks         (locks),
      .cfg_rdata     (cfg_rdata),
      .sw_rst_pulse  (sw_rst_pulse)
   );

   lcmos_lock_match #(
      .ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .SPAN_LOG2(SPAN_LOG2), .WIN_BASES(WIN_BASES)
   ) u_match (
      .addr    (acc_addr),
      .locks   (locks),
      .blocked (acc_blocked)
   );

   lcmos_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
      .clk   (clk),
      .we    (data_acc && io_we && !acc_blocked),
      .re    (data_acc && !io_we),
      .addr  (acc_addr),
      .wdata (io_wdata),
      .rdata (ram_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_q      <= '0;
         idx_snap_q <= '0;
      end else begin
         tag_q.valid   <= io_req && !io_we;
         tag_q.src     <= port;
         tag_q.blocked <= acc_blocked;
         idx_snap_q    <= (port == PORT_IDX_HI) ? idx_hi : idx_lo;
      end
   end

   always_comb begin
      io_rdata = '0;
      if (tag_q.valid) begin
         unique case (tag_q.src)
            PORT_IDX_LO, PORT_IDX_HI: io_rdata = {{(DATA_W-IDX_W){1'b0}}, idx_snap_q};
            PORT_DAT_LO, PORT_DAT_HI: io_rdata = tag_q.blocked ? LOCK_FILL : ram_rdata;
            default:                  io_rdata = '0;
         endcase
      end
   end

   assign io_rvalid = tag_q.valid;
endmodule

// File: rtl/lcmos_ctrl_chk.sv
module lcmos_ctrl_chk #(
   parameter int DATA_W    = 8,
   parameter int NUM_WIN   = 2,
   parameter int PULSE_BIT = 2,
   parameter logic [DATA_W-1:0] FILL = 8'hFF
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pwrgood_rst_n,
   input logic              io_req,
   input logic              io_we,
   input logic [1:0]        io_port,
   input logic [DATA_W-1:0] io_rdata,
   input logic              io_rvalid,
   input logic              cfg_we,
   input logic [DATA_W-1:0] cfg_wdata,
   input logic [DATA_W-1:0] cfg_rdata,
   input logic              sw_rst_pulse,
   input logic              acc_blocked
);
   for (genvar i = 0; i < NUM_WIN; i++) begin : g_lock_chk
      assert_guard_sticky_R5: assert property (@(posedge clk) disable iff (!pwrgood_rst_n)
         cfg_rdata[i] |=> cfg_rdata[i]);
      assert_guard_set_R4: assert property (@(posedge clk) disable iff (!pwrgood_rst_n)
         (cfg_we && cfg_wdata[i]) |=> cfg_rdata[i]);
   end

   assert_guarded_read_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (io_req && !io_we && io_port[0] && acc_blocked) |=> (io_rdata == FILL));

   assert_read_answer_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (io_req && !io_we) |=> io_rvalid);

   assert_no_stray_answer_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_req && !io_we) |=> !io_rvalid);

   assert_pulse_on_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_wdata[PULSE_BIT]) |=> sw_rst_pulse);

   assert_pulse_only_on_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_we && cfg_wdata[PULSE_BIT]) |=> !sw_rst_pulse);
endmodule

bind lockable_cmos_ctrl lcmos_ctrl_chk #(
   .DATA_W(DATA_W), .NUM_WIN(NUM_WIN), .PULSE_BIT(CTRL_PULSE_BIT), .FILL(LOCK_FILL)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .pwrgood_rst_n (pwrgood_rst_n),
   .io_req        (io_req),
   .io_we         (io_we),
   .io_port       (io_port),
   .io_rdata      (io_rdata),
   .io_rvalid     (io_rvalid),
   .cfg_we        (cfg_we),
   .cfg_wdata     (cfg_wdata),
   .cfg_rdata     (cfg_rdata),
   .sw_rst_pulse  (sw_rst_pulse),
   .acc_blocked   (acc_blocked)
);

// File: tb/lockable_cmos_ctrl_tb.sv
module lockable_cmos_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwrgood_rst_n = 1'b0;
   logic       io_req = 1'b0;
   logic       io_we = 1'b0;
   logic [1:0] io_port = 2'd0;
   logic [7:0] io_wdata = 8'h00;
   logic [7:0] io_rdata;
   logic       io_rvalid;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_wdata = 8'h00;
   logic [7:0] cfg_rdata;
   logic       sw_rst_pulse;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   lockable_cmos_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .pwrgood_rst_n(pwrgood_rst_n),
      .io_req(io_req), .io_we(io_we), .io_port(io_port), .io_wdata(io_wdata),
      .io_rdata(io_rdata), .io_rvalid(io_rvalid),
      .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .sw_rst_pulse(sw_rst_pulse)
   );

   // behavioural reference model
   int  m_mem [256];
   int  m_idx_lo, m_idx_hi, m_plain, m_rdata;
   bit  m_lock_lo, m_lock_hi, m_rvalid, m_pulse;

   function automatic bit in_guard(int a);
      return (m_lock_lo && a >= 'h38 && a <= 'h3F) || (m_lock_hi && a >= 'hB8 && a <= 'hBF);
   endfunction

   always @(posedge clk) begin
      int a;
      if (!pwrgood_rst_n) begin
         m_lock_lo = 0; m_lock_hi = 0;
      end
      if (!rst_n) begin
         m_idx_lo = 0; m_idx_hi = 0; m_plain = 0; m_rvalid = 0; m_pulse = 0; m_rdata = 0;
         if (pwrgood_rst_n && cfg_we) begin
            if (cfg_wdata[0]) m_lock_lo = 1;
            if (cfg_wdata[1]) m_lock_hi = 1;
         end
      end else begin
         a = (io_port == 2'd3) ? (128 + m_idx_hi) : m_idx_lo;
         m_rvalid = io_req && !io_we;
         m_rdata  = 0;
         if (io_req && !io_we) begin
            case (io_port)
               2'd0: m_rdata = m_idx_lo;
               2'd2: m_rdata = m_idx_hi;
               default: m_rdata = in_guard(a) ? 'hFF : m_mem[a];
            endcase
         end
         if (io_req && io_we) begin
            case (io_port)
               2'd0: m_idx_lo = io_wdata & 'h7F;
               2'd2: m_idx_hi = io_wdata & 'h7F;
               default: if (!in_guard(a)) m_mem[a] = io_wdata;
            endcase
         end
         m_pulse = cfg_we && cfg_wdata[2];
         if (cfg_we) begin
            m_plain = cfg_wdata & 'hF8;
            if (pwrgood_rst_n) begin
               if (cfg_wdata[0]) m_lock_lo = 1;
               if (cfg_wdata[1]) m_lock_hi = 1;
            end
         end
      end
   end

   task automatic check(bit ok, string req, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   bit started = 1'b0;

   always @(negedge clk) begin
      if (started) begin
         check(io_rvalid == m_rvalid, "R2 rvalid", int'(io_rvalid), int'(m_rvalid));
         check(io_rdata == m_rdata[7:0], "R2 rdata", int'(io_rdata), m_rdata);
         check(cfg_rdata == 8'(m_plain | (int'(m_lock_hi) << 1) | int'(m_lock_lo)),
               "R4 cfg", int'(cfg_rdata), m_plain | (int'(m_lock_hi) << 1) | int'(m_lock_lo));
         check(sw_rst_pulse == m_pulse, "R10 pulse", int'(sw_rst_pulse), int'(m_pulse));
      end
   end

   task automatic io_op(int port, bit we, int data);
      io_req = 1'b1; io_we = we; io_port = 2'(port); io_wdata = 8'(data);
      @(negedge clk);
      io_req = 1'b0; io_we = 1'b0;
   endtask

   task automatic wr_byte(int addr, int data);
      if (addr < 128) begin io_op(0, 1, addr); io_op(1, 1, data); end
      else begin io_op(2, 1, addr - 128); io_op(3, 1, data); end
   endtask

   task automatic rd_expect(int addr, int exp, string req);
      if (addr < 128) begin io_op(0, 1, addr); io_op(1, 0, 0); end
      else begin io_op(2, 1, addr - 128); io_op(3, 0, 0); end
      check(io_rvalid && io_rdata == 8'(exp), req, int'(io_rdata), exp);
   endtask

   task automatic cfg_wr(int data);
      cfg_we = 1'b1; cfg_wdata = 8'(data);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   function automatic int pat(int a);
      return (a ^ 'h5A) & 'hFF;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      started = 1'b1;
      rst_n = 1'b1; pwrgood_rst_n = 1'b1;
      @(negedge clk);
      // reset state (R9)
      check(cfg_rdata == 8'h00, "R9 reset cfg", int'(cfg_rdata), 0);
      check(io_rvalid == 1'b0, "R2 reset rvalid", int'(io_rvalid), 0);

      for (int a = 0; a < 256; a++) wr_byte(a, pat(a));
      rd_expect('h00, pat('h00), "R2 low bank");
      rd_expect('h7F, pat('h7F), "R2 low top");
      rd_expect('h80, pat('h80), "R2 high bank");
      rd_expect('hFF, pat('hFF), "R2 high top");

      // index latch drops bit 7 (R1), read-back (R3)
      io_op(0, 1, 'hC5); io_op(0, 0, 0);
      check(io_rdata == 8'h45, "R1 R3 low index", int'(io_rdata), 'h45);
      io_op(1, 0, 0);
      check(io_rdata == 8'(pat('h45)), "R1 low data", int'(io_rdata), pat('h45));
      io_op(2, 1, 'h93); io_op(2, 0, 0);
      check(io_rdata == 8'h13, "R3 high index", int'(io_rdata), 'h13);

      // plain bits and write-only pulse bit
      cfg_wr('hF8);
      check(cfg_rdata == 8'hF8, "R9 plain bits", int'(cfg_rdata), 'hF8);
      cfg_we = 1'b1; cfg_wdata = 8'h04;
      @(negedge clk);
      cfg_we = 1'b0;
      check(sw_rst_pulse == 1'b1, "R10 pulse high", int'(sw_rst_pulse), 1);
      check(cfg_rdata[2] == 1'b0, "R10 reads zero", int'(cfg_rdata), 0);
      @(negedge clk);
      check(sw_rst_pulse == 1'b0, "R10 pulse single", int'(sw_rst_pulse), 0);

      wr_byte('h38, 'h11); wr_byte('h3F, 'h12); wr_byte('hB8, 'h21); wr_byte('hBF, 'h22);
      cfg_wr('h01);
      check(cfg_rdata == 8'h01, "R4 low guard set", int'(cfg_rdata), 1);
      rd_expect('h38, 'hFF, "R6 low window first");
      rd_expect('h3F, 'hFF, "R6 low window last");
      rd_expect('h37, pat('h37), "R8 below window");
      rd_expect('h40, pat('h40), "R8 above window");
      rd_expect('hB8, 'h21, "R8 other window open");
      wr_byte('h38, 'hAA); wr_byte('h3C, 'hAB);
      rd_expect('h3C, 'hFF, "R7 R6 guarded after write");
      wr_byte('h37, 'h77);
      rd_expect('h37, 'h77, "R8 neighbour writable");
      cfg_wr('h00);
      check(cfg_rdata[0] == 1'b1, "R4 zero write ignored", int'(cfg_rdata), 1);
      cfg_wr('h02);
      rd_expect('hB8, 'hFF, "R6 high window");
      rd_expect('hBF, 'hFF, "R6 high window last");
      rd_expect('hB7, pat('hB7), "R8 high below");
      rd_expect('hC0, pat('hC0), "R8 high above");
      wr_byte('hBF, 'hCC);

      // system reset keeps guards
      cfg_wr('hA8);
      rst_n = 1'b0;
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(cfg_rdata == 8'h03, "R5 R9 guards survive rst", int'(cfg_rdata), 3);
      rd_expect('h38, 'hFF, "R5 still guarded");

      // power-good reset releases guards; discarded writes left no trace
      pwrgood_rst_n = 1'b0; rst_n = 1'b0;
      @(negedge clk); @(negedge clk);
      pwrgood_rst_n = 1'b1; rst_n = 1'b1;
      @(negedge clk);
      check(cfg_rdata == 8'h00, "R5 power-good clears", int'(cfg_rdata), 0);
      rd_expect('h38, 'h11, "R7 low byte kept");
      rd_expect('h3C, pat('h3C), "R7 low mid kept");
      rd_expect('hBF, 'h22, "R7 high byte kept");
      wr_byte('h3A, 'h5E);
      rd_expect('h3A, 'h5E, "R8 window writable when open");

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule